// File: doc/BRIEF.md
# Serial Scan Loader for a Word Memory

This block gives a one-bit scan path access to a memory of 1024 words, 16 bits each. It runs on the test clock `tck`. A test controller outside the block decodes its state machine and instructions. The controller drives four things into the block: the scan phase strobes (`capture`, `shift_en`, `update`), the mode select (`stream_mode`), the transfer direction (`write_dir`) and the arming strobe (`arm_go`). Serial data enters on `tdi` and leaves on `tdo`, least significant bit first.

In addressed mode the scan register is 26 bits wide. Bits [15:0] hold a data word and bits [25:16] hold an address. An update with the write direction stores the data word at that address. A capture reloads the data bits from that address, so they can be shifted out.

In streaming mode only the 16-bit data part is in the path. A capture loads the stream pointer from `base_addr`. The pointer then advances after every 16 shifted bits, so whole blocks of words move in one long shift. A streaming read preloads each following word on the edge that finishes the previous one, so the output has no gap between words. A streaming write stays idle until the serial stream carries the 8-bit `header` pattern, or until `arm_go` is pulsed. When `header` is zero, pattern arming is switched off.

The serial path has no valid/ready handshake. The stream stalls only by holding `shift_en` low. That is a back-pressure point with a cost: in streaming-write mode, holding `shift_en` low drops the arming, and the partly shifted word is lost.

Top module: `scan_ram_loader`

## Requirements
- R1: While `rst_n` is low and after its release, `tdo` reads 0 and a streaming write is disarmed.
- R2: In addressed mode, the 26 bits are shifted in LSB first, with data in bits [15:0] and address in bits [25:16]. An `update` with `write_dir`=1 stores the data bits at that address.
- R3: In addressed mode, `capture` loads bits [15:0] of the scan register from the word at the address in bits [25:16]. `tdo` then presents that word, bit 0 first.
- R4: In streaming mode the pointer starts at `base_addr` on `capture` and steps by one after every 16 counted shift edges. It wraps from 3FFh to 000h.
- R5: A streaming write arms when the 8 most recent shifted bits equal a nonzero `header`. The header is sent LSB first, so the newest bit is header bit 7. Bits shifted before arming are never stored. The next 16 bits, LSB first, form the word at the pointer.
- R6: With `header` at 00h, no bit pattern arms a streaming write; only an `arm_go` pulse does.
- R7: A streaming write disarms on the first cycle with `shift_en` low. A partly shifted word is discarded, and later shifting stores nothing until the block is armed again.
- R8: A streaming read puts the word at `base_addr` on `tdo` right after `capture`. Each following word starts on the very next shift edge after the 16th bit of the previous one.
- R9: An `update` with `write_dir`=0 leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture | input | 1 | Capture phase strobe |
| shift_en | input | 1 | Shift phase enable |
| update | input | 1 | Update phase strobe |
| stream_mode | input | 1 | 1 = streaming mode, 0 = addressed mode |
| write_dir | input | 1 | 1 = write to memory, 0 = read |
| arm_go | input | 1 | Explicit arming of a streaming write |
| header | input | 8 | Arming pattern; 00h disables pattern arming |
| base_addr | input | 10 | Start address for streaming |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the scan register) |

## Verification
The checker assumes the following about the inputs:
- `capture`, `shift_en` and `update` are never asserted in the same cycle.
- `stream_mode` and `write_dir` stay constant between a capture and the end of the following shift run.
- `arm_go` is only pulsed outside a shift run.

The bench drives every input half a cycle away from the clock edge and uses one phase strobe at a time. It sets mode and direction before each capture and pulses `arm_go` only in the idle cycle after a capture, so the arming and pointer properties are checked only on legal traffic.

// File: rtl/scan_ram_pkg.sv
package scan_ram_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_ADDR_W = 10;
  localparam int DEF_HDR_W  = 8;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_CAPTURE,
    OP_SHIFT,
    OP_UPDATE
  } scan_op_e;
endpackage

// File: rtl/srl_mem.sv
module srl_mem #(
  parameter int DATA_W = scan_ram_pkg::DEF_DATA_W,
  parameter int ADDR_W = scan_ram_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/srl_hdr_match.sv
module srl_hdr_match #(
  parameter int HDR_W = scan_ram_pkg::DEF_HDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_in,
  input  logic [HDR_W-1:0] header,
  output logic             hit
);
  localparam int SEEN_W = $clog2(HDR_W + 1);

  // history of the last HDR_W-1 bits; newest bit at the top
  logic [HDR_W-2:0]  hist;
  logic [SEEN_W-1:0] seen;
  logic [HDR_W-1:0]  window;

  assign window = {bit_in, hist};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      seen <= '0;
    end else if (clear) begin
      hist <= '0;
      seen <= '0;
    end else if (shift) begin
      hist <= window[HDR_W-1:1];
      if (seen != SEEN_W'(HDR_W)) seen <= seen + 1'b1;
    end
  end

  assign hit = shift && (header != '0) && (seen >= SEEN_W'(HDR_W - 1)) && (window == header);
endmodule

// File: rtl/srl_stream_ctl.sv
module srl_stream_ctl #(
  parameter int DATA_W = scan_ram_pkg::DEF_DATA_W,
  parameter int ADDR_W = scan_ram_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift_en,
  input  logic              stream_mode,
  input  logic              write_dir,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              arm_go,
  input  logic              hdr_hit,
  output logic [ADDR_W-1:0] ptr,
  output logic              armed,
  output logic              word_tick
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] bit_cnt;
  logic             shift_q;
  logic             arm_ok;
  logic             arm_evt;
  logic             count_en;

  assign arm_ok   = stream_mode && write_dir;
  assign arm_evt  = arm_ok && !armed && (arm_go || (hdr_hit && shift_en));
  assign count_en = stream_mode && shift_en && (write_dir ? armed : 1'b1);
  assign word_tick = count_en && (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= 1'b0;
    else        shift_q <= shift_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   armed <= 1'b0;
    else if (capture)             armed <= 1'b0;
    else if (arm_go && arm_ok)    armed <= 1'b1;
    else if (shift_q && !shift_en) armed <= 1'b0;
    else if (arm_evt)             armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          bit_cnt <= '0;
    else if (capture)    bit_cnt <= '0;
    else if (arm_evt)    bit_cnt <= '0;
    else if (count_en)   bit_cnt <= word_tick ? '0 : bit_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ptr <= '0;
    else if (capture && stream_mode)  ptr <= base_addr;
    else if (word_tick)               ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/scan_ram_loader.sv
module scan_ram_loader
  import scan_ram_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int HDR_W  = DEF_HDR_W
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift_en,
  input  logic              update,
  input  logic              stream_mode,
  input  logic              write_dir,
  input  logic              arm_go,
  input  logic [HDR_W-1:0]  header,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              tdi,
  output logic              tdo
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  scan_op_e          op;
  logic [FRAME_W-1:0] sr;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] shifted_word;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              mem_we;
  logic              armed;
  logic              word_tick;
  logic              hdr_hit;
  logic              capture_act;
  logic              shift_act;

  always_comb begin
    if (capture)       op = OP_CAPTURE;
    else if (update)   op = OP_UPDATE;
    else if (shift_en) op = OP_SHIFT;
    else               op = OP_IDLE;
  end

  assign capture_act  = (op == OP_CAPTURE);
  assign shift_act    = (op == OP_SHIFT);
  assign frame_addr   = sr[FRAME_W-1:DATA_W];
  assign shifted_word = {tdi, sr[DATA_W-1:1]};

  // read port: capture source or next-word preload while streaming
  always_comb begin
    if (capture_act) rd_addr = stream_mode ? base_addr : frame_addr;
    else             rd_addr = ptr + 1'b1;
  end

  always_comb begin
    mem_we  = 1'b0;
    wr_addr = frame_addr;
    wr_data = sr[DATA_W-1:0];
    if (stream_mode) begin
      wr_addr = ptr;
      wr_data = shifted_word;
      mem_we  = shift_act && write_dir && word_tick;
    end else begin
      mem_we  = (op == OP_UPDATE) && write_dir;
    end
  end

  always_ff @(posedge tck) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      case (op)
        OP_CAPTURE: sr[DATA_W-1:0] <= rd_data;
        OP_SHIFT: begin
          if (!stream_mode)                 sr <= {tdi, sr[FRAME_W-1:1]};
          else if (!write_dir && word_tick) sr[DATA_W-1:0] <= rd_data;
          else                              sr[DATA_W-1:0] <= shifted_word;
        end
        default: ;
      endcase
    end
  end

  assign tdo = sr[0];

  srl_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (tck),
    .we    (mem_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  srl_hdr_match #(.HDR_W(HDR_W)) u_match (
    .clk    (tck),
    .rst_n  (rst_n),
    .clear  (capture_act),
    .shift  (shift_act && stream_mode),
    .bit_in (tdi),
    .header (header),
    .hit    (hdr_hit)
  );

  srl_stream_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk         (tck),
    .rst_n       (rst_n),
    .capture     (capture_act),
    .shift_en    (shift_act),
    .stream_mode (stream_mode),
    .write_dir   (write_dir),
    .base_addr   (base_addr),
    .arm_go      (arm_go),
    .hdr_hit     (hdr_hit),
    .ptr         (ptr),
    .armed       (armed),
    .word_tick   (word_tick)
  );
endmodule

// File: rtl/scan_ram_loader_chk.sv
module scan_ram_loader_chk #(
  parameter int ADDR_W = 10,
  parameter int HDR_W  = 8
) (
  input logic              tck,
  input logic              rst_n,
  input logic              capture_act,
  input logic              shift_act,
  input logic              stream_mode,
  input logic              write_dir,
  input logic              arm_go,
  input logic [HDR_W-1:0]  header,
  input logic              armed,
  input logic [ADDR_W-1:0] ptr,
  input logic              word_tick,
  input logic              mem_we
);
  AST_ARM_TRIGGERED: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(armed) |-> ($past(arm_go) || ($past(shift_act) && $past(header) != '0))); // R5
  AST_ZERO_HDR_STROBE_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
    ($rose(armed) && $past(header) == '0) |-> $past(arm_go)); // R6
  AST_DISARM_ON_EXIT: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_act && $past(shift_act) && !arm_go) |=> !armed); // R7
  AST_PTR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (!capture_act && !word_tick) |=> $stable(ptr)); // R4
  AST_PTR_STEP: assert property (@(posedge tck) disable iff (!rst_n)
    word_tick |=> (ptr == $past(ptr) + 1'b1)); // R4
  AST_STREAM_WRITE_ARMED: assert property (@(posedge tck) disable iff (!rst_n)
    (mem_we && stream_mode) |-> armed); // R5
  AST_READ_NO_WRITE: assert property (@(posedge tck) disable iff (!rst_n)
    !write_dir |-> !mem_we); // R9
  AST_RESET_DISARMED: assert property (@(posedge tck)
    !rst_n |=> !armed); // R1
endmodule

bind scan_ram_loader scan_ram_loader_chk #(.ADDR_W(ADDR_W), .HDR_W(HDR_W)) u_chk (
  .tck         (tck),
  .rst_n       (rst_n),
  .capture_act (capture_act),
  .shift_act   (shift_act),
  .stream_mode (stream_mode),
  .write_dir   (write_dir),
  .arm_go      (arm_go),
  .header      (header),
  .armed       (armed),
  .ptr         (ptr),
  .word_tick   (word_tick),
  .mem_we      (mem_we)
);

// File: tb/tb_scan_ram_loader.sv
module tb_scan_ram_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [25:0] VECS [NVEC] = '{
    {10'h000, 16'hC3A5},
    {10'h3FF, 16'h8001},
    {10'h155, 16'h0000},
    {10'h2AA, 16'hFFFF},
    {10'h001, 16'h7E81},
    {10'h200, 16'h5A5A}
  };

  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       capture = 1'b0, shift_en = 1'b0, update = 1'b0;
  logic       stream_mode = 1'b0, write_dir = 1'b0, arm_go = 1'b0;
  logic [7:0] header = 8'h00;
  logic [9:0] base_addr = 10'h000;
  logic       tdi = 1'b0;
  logic       tdo;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) tck = ~tck;

  scan_ram_loader dut (
    .tck(tck), .rst_n(rst_n), .capture(capture), .shift_en(shift_en), .update(update),
    .stream_mode(stream_mode), .write_dir(write_dir), .arm_go(arm_go), .header(header),
    .base_addr(base_addr), .tdi(tdi), .tdo(tdo)
  );

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      shift_en = 1'b1;
      tdi = v[i];
      step();
    end
  endtask

  task automatic idle();
    shift_en = 1'b0;
    tdi = 1'b0;
    step();
  endtask

  task automatic addr_write(input logic [9:0] a, input logic [15:0] d);
    stream_mode = 1'b0;
    shift_bits({6'h0, a, d}, 26);
    shift_en = 1'b0;
    write_dir = 1'b1;
    update = 1'b1;
    step();
    update = 1'b0;
    write_dir = 1'b0;
  endtask

  task automatic addr_read(input logic [9:0] a, output logic [15:0] d);
    stream_mode = 1'b0;
    shift_bits({6'h0, a, 16'h0000}, 26);
    shift_en = 1'b0;
    write_dir = 1'b0;
    update = 1'b1;          // read-direction update: must not write (R9)
    step();
    update = 1'b0;
    capture = 1'b1;
    step();
    capture = 1'b0;
    for (int i = 0; i < 16; i++) begin
      d[i] = tdo;
      shift_en = 1'b1;
      tdi = 1'b0;
      step();
    end
    idle();
  endtask

  task automatic stream_capture(input logic [9:0] b, input logic wr);
    stream_mode = 1'b1;
    write_dir = wr;
    base_addr = b;
    capture = 1'b1;
    step();
    capture = 1'b0;
  endtask

  task automatic stream_read_word(output logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      w[i] = tdo;
      shift_en = 1'b1;
      tdi = 1'b0;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    step();
    chk("R1 tdo during reset", 32'(tdo), 32'h0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 tdo after reset", 32'(tdo), 32'h0);

    // table walk: addressed writes, then addressed reads (R2, R3, R9)
    for (int i = 0; i < 2 * NVEC; i++) begin
      if (i < NVEC) begin
        addr_write(VECS[i][25:16], VECS[i][15:0]);
      end else begin
        addr_read(VECS[i - NVEC][25:16], rd);
        chk("R2/R3/R9 addressed readback", 32'(rd), 32'(VECS[i - NVEC][15:0]));
      end
    end

    // R5, R4: header-armed stream write across the wrap, junk bits first
    header = 8'hA5;
    stream_capture(10'h3FE, 1'b1);
    shift_bits(32'h0, 3);
    shift_bits(32'hA5, 8);
    shift_bits(32'h1234, 16);
    shift_bits(32'hBEEF, 16);
    shift_bits(32'h0F0F, 16);
    idle();
    stream_mode = 1'b0;
    addr_read(10'h3FE, rd); chk("R5 first streamed word", 32'(rd), 32'h1234);
    addr_read(10'h3FF, rd); chk("R4 second streamed word", 32'(rd), 32'hBEEF);
    addr_read(10'h000, rd); chk("R4 wrap to 000", 32'(rd), 32'h0F0F);

    // R8: gapless stream read across the wrap
    stream_capture(10'h3FE, 1'b0);
    stream_read_word(rd); chk("R8 read word 0", 32'(rd), 32'h1234);
    stream_read_word(rd); chk("R8 read word 1", 32'(rd), 32'hBEEF);
    stream_read_word(rd); chk("R8 R4 read word 2 wrapped", 32'(rd), 32'h0F0F);
    idle();

    // R6: zero header ignores pattern, strobe arms
    addr_write(10'h010, 16'hAAAA);
    header = 8'h00;
    stream_capture(10'h010, 1'b1);
    shift_bits(32'h0, 8);
    shift_bits(32'h5555, 16);
    idle();
    addr_read(10'h010, rd); chk("R6 no pattern arming", 32'(rd), 32'hAAAA);
    stream_capture(10'h010, 1'b1);
    arm_go = 1'b1;
    step();
    arm_go = 1'b0;
    shift_bits(32'h5555, 16);
    idle();
    addr_read(10'h010, rd); chk("R6 strobe arming", 32'(rd), 32'h5555);

    // R7: leaving shift disarms and drops the partial word
    addr_write(10'h020, 16'h1111);
    header = 8'hA5;
    stream_capture(10'h020, 1'b1);
    shift_bits(32'hA5, 8);
    shift_bits(32'h0, 8);
    idle();
    shift_bits(32'h0, 16);
    idle();
    addr_read(10'h020, rd); chk("R7 disarm on shift exit", 32'(rd), 32'h1111);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule